// File: doc/BRIEF.md
# Multi-Channel Edge Capture Unit

This block watches a small set of asynchronous capture pins and, when a selected transition arrives on one of them, copies the free-running timer count supplied from outside into that channel's capture register. Each channel has a three-bit control field: a rising-transition enable, a falling-transition enable and an interrupt enable. One channel can therefore record both transitions of a pulse while another records only one. The block does not generate the count.

Each pin goes through a two-flop synchronizer and then an edge detector. A capture stores the count present in the cycle where the synchronized edge is detected. For a pin change that lands between two clock edges, the capture register updates on the third rising clock edge after the change. It takes the count that was presented during the cycle just before that edge.

A capture on a channel whose interrupt enable is set also raises that channel's sticky flag. Software clears flags by pulsing a clear strobe with a bit mask. The interrupt output combines every flag whose interrupt enable is currently set.

Top module: `edge_capture_unit`

## Requirements
- R1: A qualifying edge on pin n loads `count_i` into capture register n. The value loaded is the count in the cycle before the third rising clock edge after the pin change. The register holds that value until the next capture on the same channel.
- R2: Channel n's control field is `ctl_wdata_i[3n+2:3n]`, latched when `ctl_we_i` is high. Bit 3n enables rising edges and bit 3n+1 enables falling edges, so the low two bits read 1 = rising only, 2 = falling only, 3 = both. Bit 3n+2 is the interrupt enable.
- R3: With both edge enables of a channel clear, no transition on its pin changes its capture register or its flag.
- R4: A capture on a channel with its interrupt enable set sets that channel's flag. A capture with the interrupt enable clear leaves the flag unchanged.
- R5: A cycle with `clr_we_i` high clears every flag whose bit in `clr_mask_i` is 1 and leaves the other flags unchanged.
- R6: If a clear of a channel's flag and a capture that sets that flag fall in the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly when some flag is set whose interrupt enable is currently set. Clearing an interrupt enable masks `irq_o` but keeps the flag.
- R8: After reset all capture registers, all flags, all control fields and `irq_o` are zero.
- R9: Channels are independent. Transitions on several pins in the same cycle are each captured according to their own channel's field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Running timer count to be sampled |
| cap_pin_i | input | NUM_CH | Asynchronous capture pins, one per channel |
| ctl_we_i | input | 1 | Write strobe for the control fields |
| ctl_wdata_i | input | 3*NUM_CH | Control fields, 3 bits per channel |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | NUM_CH | Flags to clear when the strobe is high |
| cap_val_o | output | NUM_CH*CNT_W | Capture registers, channel n at bits [n*CNT_W +: CNT_W] |
| flag_o | output | NUM_CH | Capture flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
A capture that sets a flag and a software clear of the same flag can land on one clock edge. The bench provokes this by raising the clear strobe on the falling edge just before the capturing rising edge. The clear mask covers both the capturing channel and an idle channel whose flag is already set. The judgement is that the capturing channel's flag stays set, the idle channel's flag drops, and the capture value is still loaded.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  localparam int FIELD_W = 3;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } ecu_field_t;

  // Qualifying-edge decision for one channel.
  function automatic logic edge_hit(ecu_field_t f, logic rise, logic fall);
    return (rise & f.rise_en) | (fall & f.fall_en);
  endfunction

  // Next flag value: a set in the same cycle overrides a clear.
  function automatic logic flag_next(logic cur, logic clr, logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/ecu_edge_det.sv
module ecu_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
  import ecu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  ecu_field_t       field_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             evt_o
);
  logic set_w;

  assign evt_o = edge_hit(field_i, rise_i, fall_i);
  assign set_w = evt_o & field_i.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (evt_o) cap_o <= count_i;
      flag_o <= flag_next(flag_o, clr_i, set_w);
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [NUM_CH-1:0]       cap_pin_i,
  input  logic                    ctl_we_i,
  input  logic [FIELD_W*NUM_CH-1:0] ctl_wdata_i,
  input  logic                    clr_we_i,
  input  logic [NUM_CH-1:0]       clr_mask_i,
  output logic [NUM_CH*CNT_W-1:0] cap_val_o,
  output logic [NUM_CH-1:0]       flag_o,
  output logic                    irq_o
);
  localparam int CTL_W = FIELD_W * NUM_CH;

  logic [CTL_W-1:0]  ctl_q;
  logic [NUM_CH-1:0] rise_w, fall_w, evt_w, ie_w, clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end

  assign clr_w = clr_we_i ? clr_mask_i : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ecu_field_t fld;
    assign fld     = ecu_field_t'(ctl_q[g*FIELD_W +: FIELD_W]);
    assign ie_w[g] = fld.irq_en;

    ecu_edge_det u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin_i[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );

    ecu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise_w[g]),
      .fall_i  (fall_w[g]),
      .field_i (fld),
      .count_i (count_i),
      .clr_i   (clr_w[g]),
      .cap_o   (cap_val_o[g*CNT_W +: CNT_W]),
      .flag_o  (flag_o[g]),
      .evt_o   (evt_w[g])
    );
  end

  assign irq_o = |(flag_o & ie_w);
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        count_i,
  input logic                    clr_we_i,
  input logic [NUM_CH-1:0]       clr_mask_i,
  input logic [3*NUM_CH-1:0]     ctl_q,
  input logic [NUM_CH-1:0]       rise_w,
  input logic [NUM_CH-1:0]       fall_w,
  input logic [NUM_CH-1:0]       evt_w,
  input logic [NUM_CH*CNT_W-1:0] cap_val_o,
  input logic [NUM_CH-1:0]       flag_o,
  input logic                    irq_o
);
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o != '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R1: captured value is the count seen in the detection cycle
    a_r1_cap_loads: assert property (@(posedge clk) disable iff (!rst_n)
      evt_w[g] |=> cap_val_o[g*CNT_W +: CNT_W] == $past(count_i));
    // R3: without an event the capture register holds
    a_r3_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_w[g] |=> $stable(cap_val_o[g*CNT_W +: CNT_W]));
    // R2: an event needs a detected edge
    a_r2_evt_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      evt_w[g] |-> (rise_w[g] | fall_w[g]));
    // R4: enabled capture sets the flag
    a_r4_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_w[g] && ctl_q[3*g+2]) |=> flag_o[g]);
    // R5: clear without a competing set drops the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_mask_i[g] && !(evt_w[g] && ctl_q[3*g+2])) |=> !flag_o[g]);
    // R6: a set beats a clear in the same cycle
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_mask_i[g] && evt_w[g] && ctl_q[3*g+2]) |=> flag_o[g]);
  end
endmodule

bind edge_capture_unit ecu_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_i    (count_i),
  .clr_we_i   (clr_we_i),
  .clr_mask_i (clr_mask_i),
  .ctl_q      (ctl_q),
  .rise_w     (rise_w),
  .fall_w     (fall_w),
  .evt_w      (evt_w),
  .cap_val_o  (cap_val_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n = 0;
  always @(negedge clk) n <= n + 1;

  function automatic logic [CW-1:0] cnt_of(int k);
    return CW'(k * 37 + 11);
  endfunction

  logic [CW-1:0]       count;
  logic [NCH-1:0]      pins = '0;
  logic                ctl_we = 1'b0;
  logic [3*NCH-1:0]    ctl_wdata = '0;
  logic                clr_we = 1'b0;
  logic [NCH-1:0]      clr_mask = '0;
  logic [NCH*CW-1:0]   cap_flat;
  logic [NCH-1:0]      flags;
  logic                irq;

  assign count = cnt_of(n);

  edge_capture_unit #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(count), .cap_pin_i(pins),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .cap_val_o(cap_flat), .flag_o(flags), .irq_o(irq)
  );

  int checks = 0;
  int failures = 0;
  logic [CW-1:0]    exp_cap [NCH];
  logic [NCH-1:0]   exp_flag = '0;
  logic [3*NCH-1:0] cfg = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] ie_vec();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = cfg[3*i+2];
    return v;
  endfunction

  task automatic check_all(string req);
    for (int i = 0; i < NCH; i++)
      chk(req, $sformatf("cap%0d", i), 32'(cap_flat[i*CW +: CW]), 32'(exp_cap[i]));
    chk(req, "flags", 32'(flags), 32'(exp_flag));
    chk(req, "irq", 32'(irq), 32'(|(exp_flag & ie_vec())));
  endtask

  task automatic set_cfg(logic [3*NCH-1:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0; cfg = v;
  endtask

  task automatic clear(logic [NCH-1:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; exp_flag = exp_flag & ~m;
  endtask

  // Change pins; optionally collide a clear with the capturing edge.
  task automatic drive(logic [NCH-1:0] np, bit collide, logic [NCH-1:0] cm);
    int n0;
    logic [NCH-1:0] old, setv;
    old = pins;
    setv = '0;
    @(negedge clk);
    pins = np;
    #1 n0 = n;
    for (int i = 0; i < NCH; i++) begin
      if ((~old[i] & np[i] & cfg[3*i]) | (old[i] & ~np[i] & cfg[3*i+1])) begin
        exp_cap[i] = cnt_of(n0 + 2);
        if (cfg[3*i+2]) setv[i] = 1'b1;
      end
    end
    @(negedge clk);
    @(negedge clk);
    if (collide) begin clr_we = 1'b1; clr_mask = cm; end
    @(negedge clk);
    clr_we = 1'b0;
    exp_flag = collide ? ((exp_flag & ~cm) | setv) : (exp_flag | setv);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) exp_cap[i] = '0;
    repeat (3) @(negedge clk);
    check_all("R8 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep every field value on every channel: R1 R2 R3 R4
    for (int ch = 0; ch < NCH; ch++) begin
      for (int v = 0; v < 8; v++) begin
        set_cfg((3*NCH)'(v) << (3*ch));
        clear('1);
        drive(pins | (NCH'(1) << ch), 1'b0, '0);
        check_all($sformatf("R1/R2 rise ch%0d cfg%0d", ch, v));
        drive(pins & ~(NCH'(1) << ch), 1'b0, '0);
        check_all($sformatf("R3/R4 fall ch%0d cfg%0d", ch, v));
      end
    end

    // R9: simultaneous edges, mixed fields (ch0 rise, ch1 fall, ch2 both, ch3 none)
    set_cfg({3'b100, 3'b111, 3'b110, 3'b101});
    clear('1);
    drive('1, 1'b0, '0);
    check_all("R9 all rise");
    drive('0, 1'b0, '0);
    check_all("R9 all fall");

    // R5: partial clear
    set_cfg({NCH{3'b111}});
    drive('1, 1'b0, '0);
    check_all("R5 setup");
    clear(4'b0101);
    check_all("R5 partial clear");

    // R6: clear collides with capture on ch1, ch3 plain-cleared
    drive(4'b1000, 1'b1, 4'b1010);
    check_all("R6 collision");
    chk("R6", "flag1", 32'(flags[1]), 32'd1);
    chk("R5", "flag3", 32'(flags[3]), 32'd0);

    // R7: removing interrupt enables masks irq, flag persists
    drive(4'b1111, 1'b0, '0);
    set_cfg({NCH{3'b011}});
    check_all("R7 masked");
    chk("R7", "irq", 32'(irq), 32'd0);
    set_cfg({3'b011, 3'b011, 3'b111, 3'b011});
    check_all("R7 unmasked");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule